// File: doc/BRIEF.md
# Cluster Power Sequencer with Shared Operating-Point Stepping

This block steers the power state of every core in a multicore cluster and moves the operating point that all cores share. For each core a two-bit software target chooses between running, a retained sleep, and full shutdown. The block walks that core through a fixed handshake order over its three domains. The always-on domain keeps the wake input alive. The core-logic domain is either held in retention while asleep or cut off by its power switch after a save handshake. The domain that holds the visible registers and SRAM is held in a low-voltage retention mode whenever the core is not running.

Frequency and voltage are common to the cluster. A performance target is reached one frequency step at a time, with a dwell between steps. The supply moves from the low to the high level only when the frequency must cross a threshold step. On the way up the voltage rises first and the frequency stays at the threshold until the regulator confirms it has settled. On the way down the frequency falls to the threshold before the voltage drops. A low-power hint for the coherency logic is raised while no more than one core is powered.

Top module: `pmu_cluster`

## Requirements
- R1: After reset every core is running with all of its control outputs low, the frequency step is 0, the high-voltage output is low, and the coherency low-power hint is low.
- R2: The target code for a core is 2'b00 for run, 2'b01 for sleep, and 2'b10 or 2'b11 for off. Leaving the run state toward sleep or off first raises the save request, which stays high until the save acknowledge is sampled. In the next cycle isolation rises alone. One cycle later core-logic retention and register low-voltage retention rise together.
- R3: With target sleep the core stops after retention. Isolation and both retention outputs stay high, and the power switch output stays low. A target of off given to a sleeping core raises the switch-off output in the next cycle.
- R4: Power-up undoes the power-down steps in reverse order. From off, the switch closes first while isolation and retention are still held. One cycle later both retentions drop. One cycle after that isolation drops and the restore request rises and stays high until the restore acknowledge is sampled, after which all outputs are low. From sleep the sequence starts at the retention release.
- R5: A wake pulse on a core starts that core's power-up even when its target is sleep or off. A pulse that arrives while the core is powering down is kept, and the core comes back up as soon as its power-down completes. A woken core then stays running until its target input changes value.
- R6: The frequency step never changes by more than one step between consecutive cycles.
- R7: The high-voltage output rises before the frequency goes above the threshold step (3 by default). The frequency stays at the threshold until the voltage settle acknowledge is sampled.
- R8: When lowering, the high-voltage output falls only once the frequency step is at or below the threshold, and only if the target is also at or below it. The frequency then continues down to the target.
- R9: The coherency low-power hint is high exactly when at least all but one of the cores are in the full-off state. A sleeping core or one that is mid-sequence counts as powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreTgt | input | 2*NUM_CORES | Per-core target, two bits per core (00 run, 01 sleep, 1x off) |
| coreWake | input | NUM_CORES | Per-core wake event from the always-on domain |
| saveAck | input | NUM_CORES | Per-core state-save done |
| restoreAck | input | NUM_CORES | Per-core state-restore done |
| perfTarget | input | $clog2(NUM_STEPS) | Requested frequency step for the cluster |
| voltAck | input | 1 | Regulator settled after a voltage change |
| saveReq | output | NUM_CORES | Per-core state-save request |
| isoEn | output | NUM_CORES | Per-core output isolation |
| logicRet | output | NUM_CORES | Per-core core-logic retention |
| regsLowV | output | NUM_CORES | Per-core register/SRAM low-voltage retention |
| pwrSwOff | output | NUM_CORES | Per-core core-logic power switch open |
| restoreReq | output | NUM_CORES | Per-core state-restore request |
| freqStep | output | $clog2(NUM_STEPS) | Cluster frequency step toward the clock generator |
| voltHigh | output | 1 | Cluster voltage level toward the regulator |
| cohLowPwr | output | 1 | Coherency logic may enter low power |

## Verification
A wake event and a software power-down can land on the same core in overlapping cycles. The bench provokes this by pulsing wake while the save request is still pending and the target says off. It then requires the whole power-down to run to the switch-open state, followed directly by the reverse sequence, with no further software action. The core is then expected to stay running for several cycles while its target still reads off. Separately, a change of target to sleep for a woken core is required to start a fresh power-down in the very next cycle, which shows that the wake hold was released by the target change.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [3:0] {
    C_ON,
    C_PD_SAVE,
    C_PD_ISO,
    C_PD_RET,
    C_SLEEP,
    C_OFF,
    C_PU_SW,
    C_PU_RET,
    C_PU_RST
  } coreState_t;

  typedef enum logic [1:0] {
    D_IDLE,
    D_DWELL,
    D_VWAIT
  } dvfsState_t;

  // strobes from the stepping control into the operating-point datapath
  typedef struct packed {
    logic incFreq;
    logic decFreq;
    logic voltUp;
    logic voltDown;
  } dvfsStrobe_t;

  typedef struct packed {
    logic saveReq;
    logic iso;
    logic logicRet;
    logic regsLowV;
    logic swOff;
    logic restoreReq;
  } coreCtl_t;

  localparam logic [1:0] TGT_ON = 2'b00;

endpackage

// File: rtl/pmu_core_seq.sv
module pmu_core_seq
  import pmu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] tgt,
  input  logic       wake,
  input  logic       saveAck,
  input  logic       restoreAck,
  output coreCtl_t   ctl,
  output logic       isOff
);

  coreState_t state;
  coreState_t nxtState;
  logic       holdOn;
  logic [1:0] prevTgt;
  logic       tgtChanged;
  logic       wantOn;
  logic       wantOff;
  logic       upReq;

  assign tgtChanged = (tgt != prevTgt);
  assign wantOn     = (tgt == TGT_ON);
  assign wantOff    = tgt[1];
  assign upReq      = wantOn || wake || holdOn;

  always_comb begin
    nxtState = state;
    case (state)
      C_ON:      if (!wantOn && !wake && (!holdOn || tgtChanged)) nxtState = C_PD_SAVE;
      C_PD_SAVE: if (saveAck) nxtState = C_PD_ISO;
      C_PD_ISO:  nxtState = C_PD_RET;
      C_PD_RET:  nxtState = wantOff ? C_OFF : C_SLEEP;
      C_SLEEP: begin
        if (upReq)        nxtState = C_PU_RET;
        else if (wantOff) nxtState = C_OFF;
      end
      C_OFF:     if (upReq) nxtState = C_PU_SW;
      C_PU_SW:   nxtState = C_PU_RET;
      C_PU_RET:  nxtState = C_PU_RST;
      C_PU_RST:  if (restoreAck) nxtState = C_ON;
      default:   nxtState = C_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= C_ON;
      holdOn  <= 1'b0;
      prevTgt <= TGT_ON;
    end else begin
      state   <= nxtState;
      prevTgt <= tgt;
      if (wake)                      holdOn <= 1'b1;
      else if (tgtChanged || wantOn) holdOn <= 1'b0;
    end
  end

  always_comb begin
    ctl = '0;
    case (state)
      C_PD_SAVE: ctl.saveReq = 1'b1;
      C_PD_ISO:  ctl.iso = 1'b1;
      C_PD_RET, C_SLEEP, C_PU_SW: begin
        ctl.iso      = 1'b1;
        ctl.logicRet = 1'b1;
        ctl.regsLowV = 1'b1;
      end
      C_OFF: begin
        ctl.iso      = 1'b1;
        ctl.logicRet = 1'b1;
        ctl.regsLowV = 1'b1;
        ctl.swOff    = 1'b1;
      end
      C_PU_RET:  ctl.iso = 1'b1;
      C_PU_RST:  ctl.restoreReq = 1'b1;
      default:   ctl = '0;
    endcase
  end

  assign isOff = (state == C_OFF);

endmodule

// File: rtl/pmu_dvfs_ctrl.sv
module pmu_dvfs_ctrl
  import pmu_pkg::*;
#(
  parameter int STEP_W      = 3,
  parameter int FREQ_THRESH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STEP_W-1:0] tgt,
  input  logic [STEP_W-1:0] freq,
  input  logic              voltHigh,
  input  logic              voltAck,
  input  logic              dwellDone,
  output dvfsStrobe_t       stb
);

  localparam logic [STEP_W-1:0] THRESH_S = STEP_W'(FREQ_THRESH);

  dvfsState_t state;
  dvfsState_t nxtState;

  always_comb begin
    nxtState = state;
    stb      = '0;
    case (state)
      D_IDLE: begin
        if (voltHigh && (freq <= THRESH_S) && (tgt <= THRESH_S)) begin
          stb.voltDown = 1'b1;
          nxtState     = D_VWAIT;
        end else if (tgt > freq) begin
          if ((freq >= THRESH_S) && !voltHigh) begin
            stb.voltUp = 1'b1;
            nxtState   = D_VWAIT;
          end else begin
            stb.incFreq = 1'b1;
            nxtState    = D_DWELL;
          end
        end else if (tgt < freq) begin
          stb.decFreq = 1'b1;
          nxtState    = D_DWELL;
        end
      end
      D_DWELL: if (dwellDone) nxtState = D_IDLE;
      D_VWAIT: if (voltAck)   nxtState = D_IDLE;
      default: nxtState = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= D_IDLE;
    else       state <= nxtState;
  end

endmodule

// File: rtl/pmu_dvfs_dp.sv
module pmu_dvfs_dp
  import pmu_pkg::*;
#(
  parameter int STEP_W    = 3,
  parameter int NUM_STEPS = 8,
  parameter int DWELL_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dvfsStrobe_t       stb,
  output logic [STEP_W-1:0] freq,
  output logic              voltHigh,
  output logic              dwellDone
);

  localparam int                DW_W     = (DWELL_CYC > 0) ? $clog2(DWELL_CYC + 1) : 1;
  localparam logic [DW_W-1:0]   DW_LOAD  = DW_W'(DWELL_CYC);
  localparam logic [STEP_W-1:0] FREQ_MAX = STEP_W'(NUM_STEPS - 1);

  logic [DW_W-1:0] dwellCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freq     <= '0;
      voltHigh <= 1'b0;
      dwellCnt <= '0;
    end else begin
      if (stb.incFreq && (freq != FREQ_MAX))  freq <= freq + 1'b1;
      else if (stb.decFreq && (freq != '0))   freq <= freq - 1'b1;
      if (stb.voltUp)        voltHigh <= 1'b1;
      else if (stb.voltDown) voltHigh <= 1'b0;
      if (stb.incFreq || stb.decFreq) dwellCnt <= DW_LOAD;
      else if (dwellCnt != '0)        dwellCnt <= dwellCnt - 1'b1;
    end
  end

  assign dwellDone = (dwellCnt == '0);

endmodule

// File: rtl/pmu_cluster.sv
module pmu_cluster
  import pmu_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_STEPS   = 8,
  parameter int FREQ_THRESH = 3,
  parameter int DWELL_CYC   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2*NUM_CORES-1:0]       coreTgt,
  input  logic [NUM_CORES-1:0]         coreWake,
  input  logic [NUM_CORES-1:0]         saveAck,
  input  logic [NUM_CORES-1:0]         restoreAck,
  input  logic [$clog2(NUM_STEPS)-1:0] perfTarget,
  input  logic                         voltAck,
  output logic [NUM_CORES-1:0]         saveReq,
  output logic [NUM_CORES-1:0]         isoEn,
  output logic [NUM_CORES-1:0]         logicRet,
  output logic [NUM_CORES-1:0]         regsLowV,
  output logic [NUM_CORES-1:0]         pwrSwOff,
  output logic [NUM_CORES-1:0]         restoreReq,
  output logic [$clog2(NUM_STEPS)-1:0] freqStep,
  output logic                         voltHigh,
  output logic                         cohLowPwr
);

  localparam int STEP_W = $clog2(NUM_STEPS);

  logic [NUM_CORES-1:0] offVec;
  dvfsStrobe_t          dvfsStb;
  logic                 dwellDone;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    coreCtl_t ctl;
    pmu_core_seq u_seq (
      .clk        (clk),
      .rstN       (rstN),
      .tgt        (coreTgt[2*c +: 2]),
      .wake       (coreWake[c]),
      .saveAck    (saveAck[c]),
      .restoreAck (restoreAck[c]),
      .ctl        (ctl),
      .isOff      (offVec[c])
    );
    assign saveReq[c]    = ctl.saveReq;
    assign isoEn[c]      = ctl.iso;
    assign logicRet[c]   = ctl.logicRet;
    assign regsLowV[c]   = ctl.regsLowV;
    assign pwrSwOff[c]   = ctl.swOff;
    assign restoreReq[c] = ctl.restoreReq;
  end

  assign cohLowPwr = ($countones(offVec) >= (NUM_CORES - 1));

  pmu_dvfs_ctrl #(
    .STEP_W      (STEP_W),
    .FREQ_THRESH (FREQ_THRESH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tgt       (perfTarget),
    .freq      (freqStep),
    .voltHigh  (voltHigh),
    .voltAck   (voltAck),
    .dwellDone (dwellDone),
    .stb       (dvfsStb)
  );

  pmu_dvfs_dp #(
    .STEP_W    (STEP_W),
    .NUM_STEPS (NUM_STEPS),
    .DWELL_CYC (DWELL_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (dvfsStb),
    .freq      (freqStep),
    .voltHigh  (voltHigh),
    .dwellDone (dwellDone)
  );

endmodule

// File: rtl/pmu_cluster_chk.sv
module pmu_cluster_chk #(
  parameter int NUM_CORES   = 4,
  parameter int NUM_STEPS   = 8,
  parameter int FREQ_THRESH = 3,
  parameter int DWELL_CYC   = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CORES-1:0]         saveReq,
  input logic [NUM_CORES-1:0]         saveAck,
  input logic [NUM_CORES-1:0]         isoEn,
  input logic [NUM_CORES-1:0]         logicRet,
  input logic [NUM_CORES-1:0]         pwrSwOff,
  input logic [$clog2(NUM_STEPS)-1:0] freqStep,
  input logic                         voltHigh,
  input logic                         cohLowPwr
);

  localparam int                STEP_W   = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] THRESH_S = STEP_W'(FREQ_THRESH);
  localparam logic [STEP_W-1:0] ONE_S    = STEP_W'(1);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assert_iso_after_save_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(isoEn[i]) |-> $past(saveReq[i] && saveAck[i]));

    assert_switch_after_ret_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwrSwOff[i]) |-> $past(logicRet[i] && isoEn[i]));

    assert_ret_held_on_close_R4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pwrSwOff[i]) |-> (isoEn[i] && logicRet[i]));

    assert_iso_drop_last_R4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(isoEn[i]) |-> (!logicRet[i] && !pwrSwOff[i]));
  end

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (freqStep != $past(freqStep)) |->
      (((freqStep - $past(freqStep)) == ONE_S) || (($past(freqStep) - freqStep) == ONE_S)));

  assert_volt_above_thresh_R7: assert property (@(posedge clk) disable iff (!rstN)
    (freqStep > THRESH_S) |-> voltHigh);

  assert_volt_drop_low_freq_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(voltHigh) |-> (freqStep <= THRESH_S));

  assert_coh_hint_R9: assert property (@(posedge clk) disable iff (!rstN)
    cohLowPwr == ($countones(pwrSwOff) >= (NUM_CORES - 1)));

endmodule

bind pmu_cluster pmu_cluster_chk #(
  .NUM_CORES   (NUM_CORES),
  .NUM_STEPS   (NUM_STEPS),
  .FREQ_THRESH (FREQ_THRESH),
  .DWELL_CYC   (DWELL_CYC)
) u_chk (.*);

// File: tb/sim_pmu_cluster.sv
module sim_pmu_cluster;

  localparam int CLK_PERIOD = 10;
  localparam int NC         = 4;
  localparam int NSTEPS     = 8;
  localparam int THR        = 3;
  localparam int SW         = $clog2(NSTEPS);

  logic            clk = 1'b0;
  logic            rstN;
  logic [2*NC-1:0] coreTgt;
  logic [NC-1:0]   coreWake;
  logic [NC-1:0]   saveAck;
  logic [NC-1:0]   restoreAck;
  logic [SW-1:0]   perfTarget;
  logic            voltAck;
  logic [NC-1:0]   saveReq;
  logic [NC-1:0]   isoEn;
  logic [NC-1:0]   logicRet;
  logic [NC-1:0]   regsLowV;
  logic [NC-1:0]   pwrSwOff;
  logic [NC-1:0]   restoreReq;
  logic [SW-1:0]   freqStep;
  logic            voltHigh;
  logic            cohLowPwr;

  int checks   = 0;
  int failures = 0;

  // regulator model state
  logic seenVolt;
  logic ackOwed;
  int   ackDly;
  logic raiseAcked;
  int   lastFreq;
  int   stepErr;
  int   voltErr;
  int   lowerErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_cluster #(
    .NUM_CORES   (NC),
    .NUM_STEPS   (NSTEPS),
    .FREQ_THRESH (THR),
    .DWELL_CYC   (2)
  ) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .coreTgt    (coreTgt),
    .coreWake   (coreWake),
    .saveAck    (saveAck),
    .restoreAck (restoreAck),
    .perfTarget (perfTarget),
    .voltAck    (voltAck),
    .saveReq    (saveReq),
    .isoEn      (isoEn),
    .logicRet   (logicRet),
    .regsLowV   (regsLowV),
    .pwrSwOff   (pwrSwOff),
    .restoreReq (restoreReq),
    .freqStep   (freqStep),
    .voltHigh   (voltHigh),
    .cohLowPwr  (cohLowPwr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // {saveReq, iso, logicRet, regsLowV, swOff, restoreReq}
  function automatic logic [5:0] ctlOf(input int c);
    return {saveReq[c], isoEn[c], logicRet[c], regsLowV[c], pwrSwOff[c], restoreReq[c]};
  endfunction

  task automatic expectCtl(input int c, input logic [5:0] exp, input string req, input string what);
    logic [5:0] act;
    act = ctlOf(c);
    check(act == exp, req, what, int'(act), int'(exp));
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  task automatic setTgt(input int c, input logic [1:0] code);
    coreTgt[2*c +: 2] = code;
  endtask

  task automatic testReset();
    check(saveReq == '0 && isoEn == '0 && logicRet == '0 && regsLowV == '0
          && pwrSwOff == '0 && restoreReq == '0, "R1", "core outputs",
          int'({saveReq, isoEn, logicRet, pwrSwOff}), 0);
    check(freqStep == '0, "R1", "freqStep", int'(freqStep), 0);
    check(voltHigh == 1'b0, "R1", "voltHigh", int'(voltHigh), 0);
    check(cohLowPwr == 1'b0, "R1", "cohLowPwr", int'(cohLowPwr), 0);
  endtask

  task automatic testDownOff();
    setTgt(1, 2'b10);
    nextCycle(); expectCtl(1, 6'b100000, "R2", "save request raised");
    nextCycle(); expectCtl(1, 6'b100000, "R2", "save held without ack");
    saveAck[1] = 1'b1;
    nextCycle(); expectCtl(1, 6'b010000, "R2", "isolation alone");
    saveAck[1] = 1'b0;
    nextCycle(); expectCtl(1, 6'b011100, "R2", "retention after iso");
    nextCycle(); expectCtl(1, 6'b011110, "R2", "switch open last");
    nextCycle(); expectCtl(1, 6'b011110, "R2", "off held");
    expectCtl(0, 6'b000000, "R2", "other core untouched");
  endtask

  task automatic testUpFromOff();
    setTgt(1, 2'b00);
    nextCycle(); expectCtl(1, 6'b011100, "R4", "switch closes first");
    nextCycle(); expectCtl(1, 6'b010000, "R4", "retention released");
    nextCycle(); expectCtl(1, 6'b000001, "R4", "iso drops restore asked");
    nextCycle(); expectCtl(1, 6'b000001, "R4", "restore held without ack");
    restoreAck[1] = 1'b1;
    nextCycle(); expectCtl(1, 6'b000000, "R4", "running after restore");
    restoreAck[1] = 1'b0;
  endtask

  task automatic testSleepWake();
    setTgt(2, 2'b01);
    nextCycle(); expectCtl(2, 6'b100000, "R3", "sleep save request");
    saveAck[2] = 1'b1;
    nextCycle(); expectCtl(2, 6'b010000, "R3", "sleep iso");
    saveAck[2] = 1'b0;
    nextCycle(); expectCtl(2, 6'b011100, "R3", "sleep retention");
    for (int k = 0; k < 5; k++) begin
      nextCycle();
      expectCtl(2, 6'b011100, "R3", "sleep keeps switch closed");
    end
    setTgt(2, 2'b11);
    nextCycle(); expectCtl(2, 6'b011110, "R3", "code 11 opens switch from sleep");
    // wake while target says off
    coreWake[2] = 1'b1;
    nextCycle(); coreWake[2] = 1'b0;
    expectCtl(2, 6'b011100, "R5", "wake starts power-up");
    nextCycle(); expectCtl(2, 6'b010000, "R5", "wake retention release");
    nextCycle(); expectCtl(2, 6'b000001, "R5", "wake restore");
    restoreAck[2] = 1'b1;
    nextCycle(); restoreAck[2] = 1'b0;
    expectCtl(2, 6'b000000, "R5", "woken core running");
    for (int k = 0; k < 8; k++) begin
      nextCycle();
      expectCtl(2, 6'b000000, "R5", "woken core held on while target off");
    end
    setTgt(2, 2'b01);
    nextCycle(); expectCtl(2, 6'b100000, "R5", "target change ends hold");
    saveAck[2] = 1'b1;
    nextCycle(); saveAck[2] = 1'b0;
    nextCycle(); nextCycle();
    expectCtl(2, 6'b011100, "R3", "back in sleep");
    setTgt(2, 2'b00);
    nextCycle(); expectCtl(2, 6'b010000, "R4", "from sleep starts at retention release");
    nextCycle(); expectCtl(2, 6'b000001, "R4", "from sleep restore");
    restoreAck[2] = 1'b1;
    nextCycle(); restoreAck[2] = 1'b0;
    expectCtl(2, 6'b000000, "R4", "from sleep running");
  endtask

  task automatic testWakeDuringDown();
    setTgt(3, 2'b10);
    nextCycle(); expectCtl(3, 6'b100000, "R5", "down started");
    coreWake[3] = 1'b1;
    nextCycle(); coreWake[3] = 1'b0;
    expectCtl(3, 6'b100000, "R5", "save still pending");
    saveAck[3] = 1'b1;
    nextCycle(); saveAck[3] = 1'b0;
    expectCtl(3, 6'b010000, "R5", "down continues iso");
    nextCycle(); expectCtl(3, 6'b011100, "R5", "down continues retention");
    nextCycle(); expectCtl(3, 6'b011110, "R5", "down reaches off");
    nextCycle(); expectCtl(3, 6'b011100, "R5", "kept wake powers up");
    nextCycle(); nextCycle();
    restoreAck[3] = 1'b1;
    nextCycle(); restoreAck[3] = 1'b0;
    expectCtl(3, 6'b000000, "R5", "running after kept wake");
    for (int k = 0; k < 5; k++) nextCycle();
    expectCtl(3, 6'b000000, "R5", "held on after kept wake");
    setTgt(3, 2'b00);
    nextCycle();
  endtask

  task automatic goDown(input int c, input logic [1:0] code);
    setTgt(c, code);
    saveAck[c] = 1'b1;
    for (int k = 0; k < 20 && !pwrSwOff[c]; k++) nextCycle();
    saveAck[c] = 1'b0;
  endtask

  task automatic goUp(input int c);
    setTgt(c, 2'b00);
    restoreAck[c] = 1'b1;
    for (int k = 0; k < 10 && ctlOf(c) != 6'b000000; k++) nextCycle();
    nextCycle();
    restoreAck[c] = 1'b0;
  endtask

  task automatic testCoherency();
    goDown(1, 2'b10);
    goDown(2, 2'b10);
    check(cohLowPwr == 1'b0, "R9", "two cores powered", int'(cohLowPwr), 0);
    setTgt(3, 2'b10);
    saveAck[3] = 1'b1;
    for (int k = 0; k < 20 && !pwrSwOff[3]; k++) begin
      nextCycle();
      if (!pwrSwOff[3])
        check(cohLowPwr == 1'b0, "R9", "hint low mid-sequence", int'(cohLowPwr), 0);
    end
    saveAck[3] = 1'b0;
    check(cohLowPwr == 1'b1, "R9", "hint high with one core left", int'(cohLowPwr), 1);
    setTgt(3, 2'b00);
    nextCycle();
    check(cohLowPwr == 1'b0, "R9", "hint drops on power-up", int'(cohLowPwr), 0);
    goUp(3);
    setTgt(3, 2'b01);
    saveAck[3] = 1'b1;
    for (int k = 0; k < 8; k++) nextCycle();
    saveAck[3] = 1'b0;
    expectCtl(3, 6'b011100, "R9", "core asleep");
    check(cohLowPwr == 1'b0, "R9", "sleeping core counts as powered", int'(cohLowPwr), 0);
    goUp(3);
    goUp(1);
    goUp(2);
  endtask

  task automatic dvfsRun(input int target, input bit ackEnable, input int cycles);
    perfTarget = SW'(target);
    for (int k = 0; k < cycles; k++) begin
      nextCycle();
      voltAck = 1'b0;
      if ((int'(freqStep) - lastFreq) > 1 || (lastFreq - int'(freqStep)) > 1) stepErr++;
      if (int'(freqStep) > THR && !(voltHigh && raiseAcked)) voltErr++;
      if (seenVolt && !voltHigh && int'(freqStep) > THR) lowerErr++;
      lastFreq = int'(freqStep);
      if (voltHigh !== seenVolt) begin
        seenVolt = voltHigh;
        ackOwed  = 1'b1;
        ackDly   = 3;
        if (voltHigh) raiseAcked = 1'b0;
      end else if (ackOwed) begin
        if (ackDly > 0) ackDly--;
        else if (ackEnable) begin
          voltAck = 1'b1;
          ackOwed = 1'b0;
          if (voltHigh) raiseAcked = 1'b1;
        end
      end
    end
  endtask

  task automatic testDvfs();
    seenVolt = 1'b0; ackOwed = 1'b0; ackDly = 0; raiseAcked = 1'b0;
    lastFreq = 0; stepErr = 0; voltErr = 0; lowerErr = 0;
    dvfsRun(2, 1'b1, 40);
    check(int'(freqStep) == 2, "R6", "reach step 2", int'(freqStep), 2);
    check(voltHigh == 1'b0, "R7", "low voltage below threshold", int'(voltHigh), 0);
    dvfsRun(6, 1'b0, 40);
    check(int'(freqStep) == THR, "R7", "freq waits at threshold", int'(freqStep), THR);
    check(voltHigh == 1'b1, "R7", "voltage raised first", int'(voltHigh), 1);
    dvfsRun(6, 1'b1, 60);
    check(int'(freqStep) == 6, "R7", "reach step 6 after settle", int'(freqStep), 6);
    dvfsRun(1, 1'b1, 60);
    check(int'(freqStep) == 1, "R8", "reach step 1", int'(freqStep), 1);
    check(voltHigh == 1'b0, "R8", "voltage lowered", int'(voltHigh), 0);
    dvfsRun(7, 1'b1, 80);
    check(int'(freqStep) == 7, "R6", "reach top step", int'(freqStep), 7);
    dvfsRun(0, 1'b1, 80);
    check(int'(freqStep) == 0, "R6", "reach step 0", int'(freqStep), 0);
    check(voltHigh == 1'b0, "R8", "low voltage at step 0", int'(voltHigh), 0);
    check(stepErr == 0, "R6", "single-step moves", stepErr, 0);
    check(voltErr == 0, "R7", "above threshold only with settled high voltage", voltErr, 0);
    check(lowerErr == 0, "R8", "voltage falls only at or below threshold", lowerErr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN       = 1'b0;
    coreTgt    = '0;
    coreWake   = '0;
    saveAck    = '0;
    restoreAck = '0;
    perfTarget = '0;
    voltAck    = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nextCycle();
    testReset();
    testDownOff();
    testUpFromOff();
    testSleepWake();
    testWakeDuringDown();
    testCoherency();
    testDvfs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule